// File: doc/BRIEF.md
# QPSK Phase-Select Timing Generator

This block is the digital timing core of a QPSK transmitter that sends a pilot tone alongside its carrier. One system clock runs everything. A one-cycle enable pulse at the master rate (nominally 2400 per second) drives all timing. The block returns that rate as a pilot strobe and divides it by two into a carrier square wave (1200 Hz). It then slices an internal pseudorandom serial stream (1200 bit/s) into dibits (600 baud). Each dibit becomes a 2-bit phase code. The code steers an external analog multiplexer to one of four carrier phases: plus cosine, plus sine, minus cosine or minus sine.

A five-state machine sequences the slots. After reset it waits in `SL_REST`. Every tick then moves it one step: `SL_REST -> SL_QHI`, `SL_QHI -> SL_QLO`, `SL_QLO -> SL_IHI`, `SL_IHI -> SL_ILO`, `SL_ILO -> SL_QHI`. Entering `SL_QHI` captures the first bit of a pair (Q). Entering `SL_IHI` captures the second bit (I) and commits the symbol. The carrier is high in both `*HI` states. One symbol therefore spans four ticks, which is exactly two carrier cycles, and it always starts on a carrier rising edge. With no tick, every state holds.

Top module: `qpsk_phase_timing`

## Requirements
- R1: While reset is low, and after release until the first tick, pilot_o, carrier_o, bit_stb_o and sym_stb_o are 0 and sel_o is 2'b00.
- R2: Each tick on tick_i produces a one-clock pulse on pilot_o in the following clock cycle. carrier_o toggles in that same cycle, so it is 0 after an even number of ticks and 1 after an odd number.
- R3: bit_stb_o pulses together with pilot_o on every tick that drives carrier_o high (the 1st, 3rd, 5th, ... tick after reset), and never otherwise.
- R4: sym_stb_o pulses together with bit_stb_o on every second bit strobe (ticks 3, 7, 11, ... after reset), so each symbol lasts four ticks, or two carrier cycles.
- R5: sel_o changes only in the clock cycle right after a sym_stb_o pulse, and holds its value at all other times.
- R6: sel_o = {Q, I}, where Q is the first bit of the pair and I the second. The codes mean 00 = +cos, 01 = +sin, 10 = -cos and 11 = -sin.
- R7: The data source is a 4-stage register s that resets to 0000. On each bit strobe its output bit s[3] is taken, and then s becomes {s[2:0], ~(s[3]^s[2])}. The bit stream after reset is therefore 000011101100101, repeating every 15 bits, and the all-ones lock-up state never occurs.
- R8: In clock cycles without a tick, carrier_o and sel_o hold and the strobes stay 0, however long the gap is.
- R9: Ticks that arrive while reset is low have no effect. The first tick after release behaves as tick 1.
- R10: Ticks on consecutive clock cycles are each counted as a full step, with no tick lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Master-rate enable pulse, one clock wide |
| pilot_o | output | 1 | Pilot strobe, registered copy of the tick |
| carrier_o | output | 1 | Carrier square wave, tick rate divided by two |
| bit_stb_o | output | 1 | Bit strobe, one pulse per serial bit |
| sym_stb_o | output | 1 | Symbol strobe, one pulse per dibit |
| sel_o | output | 2 | Phase select {Q, I} to the analog multiplexer |

## Verification
Two things can fall in the same clock cycle. One is the commit of a finished dibit onto sel_o, which happens one cycle after sym_stb_o. The other is the slot machine taking the next tick. The bench provokes this by issuing ticks on back-to-back cycles across many symbols. It then requires that every later tick still produces exactly the expected pilot, carrier and strobe values, and that sel_o lands on the expected pseudorandom pair in the right cycle. Long idle gaps and ticks sent during reset check the other side: that nothing moves without a tick.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

    // Slot sequencer states; *HI states carry a high carrier half-cycle.
    typedef enum logic [2:0] {
        SL_REST = 3'd0,
        SL_QHI  = 3'd1,
        SL_QLO  = 3'd2,
        SL_IHI  = 3'd3,
        SL_ILO  = 3'd4
    } slot_e;

    // Pseudorandom source geometry: XNOR of the top stage and one tap.
    localparam int unsigned PN_WIDTH = 4;
    localparam int unsigned PN_TAP   = 2;

    // Phase code width: bit 1 = Q, bit 0 = I.
    // 00 +cos, 01 +sin, 10 -cos, 11 -sin.
    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/qpt_slot_fsm.sv
module qpt_slot_fsm
    import qpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic carrier_o,
    output logic pilot_o,
    output logic bit_stb_o,
    output logic sym_stb_o
);

    slot_e state_q;
    slot_e state_d;
    logic  rise_d;

    // Next-state: advance one slot per tick.
    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            unique case (state_q)
                SL_REST: state_d = SL_QHI;
                SL_QHI:  state_d = SL_QLO;
                SL_QLO:  state_d = SL_IHI;
                SL_IHI:  state_d = SL_ILO;
                SL_ILO:  state_d = SL_QHI;
                default: state_d = SL_REST;
            endcase
        end
    end

    assign rise_d = (state_d == SL_QHI) || (state_d == SL_IHI);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SL_REST;
        else        state_q <= state_d;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carrier_o <= 1'b0;
            pilot_o   <= 1'b0;
            bit_stb_o <= 1'b0;
            sym_stb_o <= 1'b0;
        end else begin
            pilot_o   <= tick_i;
            bit_stb_o <= tick_i && rise_d;
            sym_stb_o <= tick_i && (state_d == SL_IHI);
            if (tick_i) carrier_o <= rise_d;
        end
    end

    // R2: a pilot strobe follows every tick
    a_r2_pilot_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pilot_o);
    // R2: carrier moves whenever the pilot strobes
    a_r2_carrier_moves: assert property (@(posedge clk) disable iff (!rst_n)
        pilot_o |-> !$stable(carrier_o));
    // R8: no pilot, no carrier change
    a_r8_carrier_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pilot_o |-> $stable(carrier_o));
    // R3: bit strobes only on carrier rising steps
    a_r3_bit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> (carrier_o && pilot_o));
    // R4: a symbol strobe is always also a bit strobe
    a_r4_sym_within_bit: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb_o |-> bit_stb_o);

endmodule

// File: rtl/qpt_pn_source.sv
module qpt_pn_source #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned TAP   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic bit_o
);

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] sreg_q;
    logic             fb;

    assign fb    = ~(sreg_q[TOP] ^ sreg_q[TAP]);
    assign bit_o = sreg_q[TOP];

    always_ff @(posedge clk) begin
        if (!rst_n)     sreg_q <= '0;
        else if (adv_i) sreg_q <= {sreg_q[TOP-1:0], fb};
    end

    // R7: the XNOR lock-up pattern is never entered
    a_r7_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        sreg_q != {WIDTH{1'b1}});

endmodule

// File: rtl/qpt_dibit_pack.sv
module qpt_dibit_pack #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             sym_stb_i,
    input  logic             bit_i,
    output logic [SEL_W-1:0] sel_o
);

    logic q_hold;

    // First bit of a pair is held; second bit commits {Q, I} together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hold <= 1'b0;
            sel_o  <= '0;
        end else if (bit_stb_i) begin
            if (sym_stb_i) sel_o  <= {q_hold, bit_i};
            else           q_hold <= bit_i;
        end
    end

    // R5: select only moves right after a symbol strobe
    a_r5_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sym_stb_i) |-> $stable(sel_o));

endmodule

// File: rtl/qpsk_phase_timing.sv
module qpsk_phase_timing
    import qpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic             pilot_o,
    output logic             carrier_o,
    output logic             bit_stb_o,
    output logic             sym_stb_o,
    output logic [SEL_W-1:0] sel_o
);

    logic data_bit;

    qpt_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .carrier_o (carrier_o),
        .pilot_o   (pilot_o),
        .bit_stb_o (bit_stb_o),
        .sym_stb_o (sym_stb_o)
    );

    qpt_pn_source #(
        .WIDTH (PN_WIDTH),
        .TAP   (PN_TAP)
    ) u_pn (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (bit_stb_o),
        .bit_o (data_bit)
    );

    qpt_dibit_pack #(
        .SEL_W (SEL_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (bit_stb_o),
        .sym_stb_i (sym_stb_o),
        .bit_i     (data_bit),
        .sel_o     (sel_o)
    );

endmodule

// File: tb/sim_qpsk_phase_timing.sv
module sim_qpsk_phase_timing;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pilot, carrier, bit_stb, sym_stb;
    logic [1:0] sel;

    always #4 clk = ~clk;

    qpsk_phase_timing u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .pilot_o   (pilot),
        .carrier_o (carrier),
        .bit_stb_o (bit_stb),
        .sym_stb_o (sym_stb),
        .sel_o     (sel)
    );

    // R7 expected serial stream from reset
    localparam logic [0:14] PN_SEQ = 15'b000011101100101;

    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    int         k = 0;
    logic       q_model = 1'b0;
    logic       sel_due = 1'b0;
    logic [1:0] sel_exp = 2'b00;
    logic [1:0] sel_next = 2'b00;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        k = 0; q_model = 1'b0; sel_due = 1'b0; sel_exp = 2'b00;
    endtask

    task automatic sel_check(input string tag);
        if (sel_due) begin
            sel_exp = sel_next;
            sel_due = 1'b0;
        end
        chk({tag, " R5 R6 R7 sel"}, sel, sel_exp);
    endtask

    // Called at a negedge; issues one tick then idles for gap cycles.
    task automatic do_tick(input string tag, input int gap);
        logic b;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        k++;
        chk({tag, " R2 pilot"},   pilot,   1);
        chk({tag, " R2 carrier"}, carrier, k % 2);
        chk({tag, " R3 bit_stb"}, bit_stb, k % 2);
        chk({tag, " R4 sym_stb"}, sym_stb, int'(k % 4 == 3));
        sel_check(tag);
        if (k % 2 == 1) begin
            b = PN_SEQ[((k - 1) / 2) % 15];
            if (k % 4 == 1) q_model = b;
            else begin
                sel_next = {q_model, b};
                sel_due  = 1'b1;
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk({tag, " R8 pilot idle"},   pilot, 0);
            chk({tag, " R8 strobes idle"}, {bit_stb, sym_stb}, 0);
            chk({tag, " R8 carrier hold"}, carrier, k % 2);
            sel_check(tag);
        end
    endtask

    task automatic check_quiet(input string tag);
        chk({tag, " R1 pilot"},   pilot,   0);
        chk({tag, " R1 carrier"}, carrier, 0);
        chk({tag, " R1 strobes"}, {bit_stb, sym_stb}, 0);
        chk({tag, " R1 sel"},     sel,     0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_quiet("reset");
        rst_n = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        check_quiet("post-reset");
    endtask

    task automatic t_slow_ticks();
        for (int i = 0; i < 16; i++) do_tick("slow", 3);
    endtask

    task automatic t_long_gap();
        do_tick("gap", 60);
        do_tick("gap", 45);
    endtask

    // R9: ticks during reset are ignored; counting restarts at tick 1
    task automatic t_reset_midrun();
        rst_n = 1'b0;
        tick  = 1'b1;
        repeat (3) @(negedge clk);
        tick  = 1'b0;
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_quiet("R9 reset-with-ticks");
        for (int i = 0; i < 8; i++) do_tick("R9 restart", 1);
    endtask

    // R10: back-to-back ticks; sel commit overlaps the next tick
    task automatic t_back_to_back();
        for (int i = 0; i < 72; i++) do_tick("R10 burst", 0);
        @(negedge clk);
        sel_check("R10 tail");
        chk("R10 tail R2 pilot", pilot, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_slow_ticks();
        t_long_gap();
        t_reset_midrun();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule